// File: doc/BRIEF.md
# Effective Address Mode Decoder

This block classifies the 6-bit mode/register field of an operand specifier, together with the operand size, into one addressing-mode class. It serves the operand-decode stage of an instruction front end. For each valid input it reports several things. It gives the register the mode names, in one 4-bit index that covers both the data and the address register files. It gives a flag vector that tells later stages how the address is built. It gives the number of 16-bit extension words the mode uses after the opcode. It raises a strobe for illegal encodings and a mark for modes that may not be used as a store destination.

The field's upper three bits are the mode and its lower three bits are the register. Mode 7 uses the register bits as a sub-mode selector. The size input is a byte count. The block does not fetch extension words, compute addresses or touch memory. Results are registered and appear one cycle after the input strobe, with their own valid.

Top module: `ea_mode_decoder`

## Requirements
- R1: When field bits [5:4] are 00, the class is register direct (code 0), reg_num equals field bits [3:0], flag bit 0 (direct) is the only flag set, and ext_words is 0.
- R2: For any field with bits [5:4] not 00, reg_num equals 8 plus field bits [2:0].
- R3: Modes 2 to 6 (field bits [5:3]) give these results. Mode 2 is plain indirect: class 2, no flags, 0 words. Mode 3 is postincrement: class 3, flag bit 2, 0 words. Mode 4 is predecrement: class 4, flag bit 3, 0 words. Mode 5 is 16-bit displacement: class 5, flag bit 4, 1 word. Mode 6 is indexed: class 6, flag bit 5, 1 word.
- R4: Mode 7 with register 0 is absolute word: class 7, flag bit 6, 1 word. Register 1 is absolute long: class 8, flag bit 6, 2 words. Register 2 is PC displacement: class 9, flag bits 7 and 4, 1 word. Register 3 is PC indexed: class 10, flag bits 7 and 5, 1 word.
- R5: Field octal 74 is immediate: class 1, flag bit 1. Its word count is 1 for a size of 1 or 2 bytes, 2 for 4 bytes, 4 for 8 bytes and 6 for 12 bytes.
- R6: Mode 7 with register 5, 6 or 7 raises illegal.
- R7: A size code other than 1, 2, 4, 8 or 12 raises illegal for every field value.
- R8: When illegal is raised, the class is 15, flags are 0, ext_words is 0 and not_alterable is 0. reg_num still follows R1/R2.
- R9: not_alterable is 1 exactly for legal immediate, PC displacement and PC indexed results.
- R10: out_valid is high in the cycle after each cycle in which in_valid is high. Outputs load only on such inputs and otherwise hold.
- R11: Synchronous reset clears out_valid and every result output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe |
| modereg | input | 6 | Mode (bits 5:3) and register (bits 2:0) field |
| size_bytes | input | 4 | Operand size as a byte count |
| out_valid | output | 1 | Result valid |
| reg_num | output | 4 | Unified register index (8 to 15 are address registers) |
| mode_class | output | 4 | Addressing-mode class code |
| flags | output | 8 | Mode flags (bit 0 direct to bit 7 PC-relative) |
| ext_words | output | 3 | Extension words the mode consumes |
| illegal | output | 1 | Illegal mode or size |
| not_alterable | output | 1 | Mode may not be a store destination |

## Verification
The bench targets the line between octal 74 and its mode-7 neighbours 73 and 75. A decoder that compares only the mode bits would take immediate as illegal, or the reverse. It sweeps all five immediate sizes, because a word count taken from the size bits instead of the threshold rule gives 3 words for 8 bytes or misses the 12-byte case. Register-direct fields with bit 3 set check that the data/address fold keeps bit 3 and does not force 8. Bad size codes paired with an otherwise legal mode show whether illegal clears every other result. It also covers hold-while-idle and a reset in mid-stream.

// File: rtl/ea_pkg.sv
package ea_pkg;

    localparam int FIELD_W = 6;
    localparam int REG_W   = 4;
    localparam int SIZE_W  = 4;
    localparam int EXT_W   = 3;
    localparam int CLS_W   = 4;

    typedef enum logic [CLS_W-1:0] {
        CLS_REG_DIRECT = 4'd0,
        CLS_IMMEDIATE  = 4'd1,
        CLS_INDIRECT   = 4'd2,
        CLS_POSTINC    = 4'd3,
        CLS_PREDEC     = 4'd4,
        CLS_DISP16     = 4'd5,
        CLS_INDEXED    = 4'd6,
        CLS_ABS_WORD   = 4'd7,
        CLS_ABS_LONG   = 4'd8,
        CLS_PC_DISP    = 4'd9,
        CLS_PC_INDEX   = 4'd10,
        CLS_INVALID    = 4'd15
    } ea_class_e;

    // bit 7 down to bit 0
    typedef struct packed {
        logic pc_rel;
        logic absolute;
        logic indexed;
        logic disp16;
        logic predec;
        logic postinc;
        logic immed;
        logic direct;
    } ea_flags_t;

    typedef struct packed {
        logic [REG_W-1:0] reg_num;
        ea_class_e        cls;
        ea_flags_t        flags;
        logic [EXT_W-1:0] ext_words;
        logic             illegal;
        logic             not_alterable;
    } ea_result_t;

    localparam int NUM_SIZES = 5;
    localparam logic [NUM_SIZES*SIZE_W-1:0] LEGAL_SIZES =
        {4'd12, 4'd8, 4'd4, 4'd2, 4'd1};

    // words of immediate data: one, more past 2, 4 and 8 bytes
    function automatic logic [EXT_W-1:0] imm_words(input logic [SIZE_W-1:0] sz);
        logic [EXT_W-1:0] w;
        w = '0;
        if (sz > 4'd0) w = w + 3'd1;
        if (sz > 4'd2) w = w + 3'd1;
        if (sz > 4'd4) w = w + 3'd2;
        if (sz > 4'd8) w = w + 3'd2;
        return w;
    endfunction

    function automatic ea_flags_t flags_of(input ea_class_e c);
        ea_flags_t f;
        f = '0;
        unique case (c)
            CLS_REG_DIRECT: f.direct   = 1'b1;
            CLS_IMMEDIATE:  f.immed    = 1'b1;
            CLS_POSTINC:    f.postinc  = 1'b1;
            CLS_PREDEC:     f.predec   = 1'b1;
            CLS_DISP16:     f.disp16   = 1'b1;
            CLS_INDEXED:    f.indexed  = 1'b1;
            CLS_ABS_WORD,
            CLS_ABS_LONG:   f.absolute = 1'b1;
            CLS_PC_DISP: begin
                f.pc_rel = 1'b1;
                f.disp16 = 1'b1;
            end
            CLS_PC_INDEX: begin
                f.pc_rel  = 1'b1;
                f.indexed = 1'b1;
            end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/ea_mode_classify.sv
module ea_mode_classify
    import ea_pkg::*;
#(
    parameter int FW = FIELD_W,
    parameter int RW = REG_W
) (
    input  logic [FW-1:0] field,
    output ea_class_e     cls,
    output logic [RW-1:0] reg_num,
    output logic          bad_mode
);
    localparam int SUB_W = FW / 2;

    logic [SUB_W-1:0] mode;
    logic [SUB_W-1:0] sub;

    assign mode = field[FW-1:SUB_W];
    assign sub  = field[SUB_W-1:0];

    always_comb begin
        if (mode[SUB_W-1:1] == '0) begin
            reg_num = field[RW-1:0];
        end else begin
            reg_num = {1'b1, sub};
        end
    end

    always_comb begin
        bad_mode = 1'b0;
        cls      = CLS_INVALID;
        unique case (mode)
            3'd0, 3'd1: cls = CLS_REG_DIRECT;
            3'd2:       cls = CLS_INDIRECT;
            3'd3:       cls = CLS_POSTINC;
            3'd4:       cls = CLS_PREDEC;
            3'd5:       cls = CLS_DISP16;
            3'd6:       cls = CLS_INDEXED;
            default: begin
                unique case (sub)
                    3'd0:    cls = CLS_ABS_WORD;
                    3'd1:    cls = CLS_ABS_LONG;
                    3'd2:    cls = CLS_PC_DISP;
                    3'd3:    cls = CLS_PC_INDEX;
                    3'd4:    cls = CLS_IMMEDIATE;
                    default: begin
                        cls      = CLS_INVALID;
                        bad_mode = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/ea_size_check.sv
module ea_size_check
    import ea_pkg::*;
#(
    parameter int SW = SIZE_W,
    parameter int N  = NUM_SIZES,
    parameter logic [N*SW-1:0] SIZES = LEGAL_SIZES
) (
    input  logic [SW-1:0] size_bytes,
    output logic          size_ok
);
    logic [N-1:0] hit;

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = (size_bytes == SIZES[i*SW +: SW]);
    end

    assign size_ok = |hit;

endmodule

// File: rtl/ea_ext_count.sv
module ea_ext_count
    import ea_pkg::*;
#(
    parameter int SW = SIZE_W,
    parameter int EW = EXT_W
) (
    input  ea_class_e     cls,
    input  logic [SW-1:0] size_bytes,
    output logic [EW-1:0] ext_words
);
    always_comb begin
        unique case (cls)
            CLS_IMMEDIATE:  ext_words = imm_words(size_bytes);
            CLS_ABS_LONG:   ext_words = EW'(2);
            CLS_ABS_WORD,
            CLS_DISP16,
            CLS_PC_DISP,
            CLS_INDEXED,
            CLS_PC_INDEX:   ext_words = EW'(1);
            default:        ext_words = '0;
        endcase
    end

endmodule

// File: rtl/ea_mode_decoder.sv
module ea_mode_decoder
    import ea_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [FIELD_W-1:0]   modereg,
    input  logic [SIZE_W-1:0]    size_bytes,
    output logic                 out_valid,
    output logic [REG_W-1:0]     reg_num,
    output logic [CLS_W-1:0]     mode_class,
    output logic [7:0]           flags,
    output logic [EXT_W-1:0]     ext_words,
    output logic                 illegal,
    output logic                 not_alterable
);
    ea_class_e        cls_raw;
    logic [REG_W-1:0] reg_raw;
    logic             bad_mode;
    logic             size_ok;
    logic [EXT_W-1:0] ext_raw;
    ea_result_t       res_d;
    ea_result_t       res_q;
    logic             vld_q;

    ea_mode_classify u_classify (
        .field    (modereg),
        .cls      (cls_raw),
        .reg_num  (reg_raw),
        .bad_mode (bad_mode)
    );

    ea_size_check u_size (
        .size_bytes (size_bytes),
        .size_ok    (size_ok)
    );

    ea_ext_count u_ext (
        .cls        (cls_raw),
        .size_bytes (size_bytes),
        .ext_words  (ext_raw)
    );

    always_comb begin
        res_d.reg_num = reg_raw;
        res_d.illegal = bad_mode | ~size_ok;
        if (res_d.illegal) begin
            res_d.cls           = CLS_INVALID;
            res_d.flags         = '0;
            res_d.ext_words     = '0;
            res_d.not_alterable = 1'b0;
        end else begin
            res_d.cls           = cls_raw;
            res_d.flags         = flags_of(cls_raw);
            res_d.ext_words     = ext_raw;
            res_d.not_alterable = (cls_raw == CLS_IMMEDIATE) |
                                  (cls_raw == CLS_PC_DISP)   |
                                  (cls_raw == CLS_PC_INDEX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid     = vld_q;
    assign reg_num       = res_q.reg_num;
    assign mode_class    = res_q.cls;
    assign flags         = res_q.flags;
    assign ext_words     = res_q.ext_words;
    assign illegal       = res_q.illegal;
    assign not_alterable = res_q.not_alterable;

endmodule

// File: rtl/ea_mode_decoder_sva.sv
module ea_mode_decoder_sva (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic [5:0] modereg,
    input logic [3:0] size_bytes,
    input logic       out_valid,
    input logic [3:0] reg_num,
    input logic [3:0] mode_class,
    input logic [7:0] flags,
    input logic [2:0] ext_words,
    input logic       illegal,
    input logic       not_alterable
);
    logic sz_good;
    assign sz_good = (size_bytes == 4'd1) || (size_bytes == 4'd2) ||
                     (size_bytes == 4'd4) || (size_bytes == 4'd8) ||
                     (size_bytes == 4'd12);

    p_direct_reg_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && modereg[5:4] == 2'b00 |=> reg_num == $past(modereg[3:0]));

    p_addr_reg_r2: assert property (@(posedge clk) disable iff (rst)
        in_valid && modereg[5:4] != 2'b00 |=> reg_num == {1'b1, $past(modereg[2:0])});

    p_bad_sub_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && modereg[5:3] == 3'd7 && modereg[2:0] > 3'd4 |=> illegal);

    p_bad_size_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && !sz_good |=> illegal);

    p_illegal_clean_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && illegal |-> flags == 8'h00 && ext_words == 3'd0 &&
                                 mode_class == 4'd15 && !not_alterable);

    p_notalt_kind_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid && not_alterable |-> flags[1] || flags[7]);

    p_valid_rise_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    p_valid_fall_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(reg_num) && $stable(mode_class) && $stable(flags) &&
                      $stable(ext_words) && $stable(illegal));

endmodule

bind ea_mode_decoder ea_mode_decoder_sva u_sva (.*);

// File: tb/ea_mode_decoder_test.sv
module ea_mode_decoder_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [5:0] modereg = '0;
    logic [3:0] size_bytes = 4'd4;
    logic       out_valid;
    logic [3:0] reg_num;
    logic [3:0] mode_class;
    logic [7:0] flags;
    logic [2:0] ext_words;
    logic       illegal;
    logic       not_alterable;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ea_mode_decoder uut (.*);

    // {field, size, reg, class, flags, words, illegal, not_alterable}
    localparam int NV = 23;
    localparam logic [30:0] VEC [NV] = '{
        {6'o03, 4'd4,  4'd3,  4'd0,  8'h01, 3'd0, 1'b0, 1'b0},
        {6'o17, 4'd4,  4'd15, 4'd0,  8'h01, 3'd0, 1'b0, 1'b0},
        {6'o25, 4'd4,  4'd13, 4'd2,  8'h00, 3'd0, 1'b0, 1'b0},
        {6'o31, 4'd2,  4'd9,  4'd3,  8'h04, 3'd0, 1'b0, 1'b0},
        {6'o47, 4'd8,  4'd15, 4'd4,  8'h08, 3'd0, 1'b0, 1'b0},
        {6'o52, 4'd4,  4'd10, 4'd5,  8'h10, 3'd1, 1'b0, 1'b0},
        {6'o60, 4'd4,  4'd8,  4'd6,  8'h20, 3'd1, 1'b0, 1'b0},
        {6'o70, 4'd4,  4'd8,  4'd7,  8'h40, 3'd1, 1'b0, 1'b0},
        {6'o71, 4'd4,  4'd9,  4'd8,  8'h40, 3'd2, 1'b0, 1'b0},
        {6'o72, 4'd4,  4'd10, 4'd9,  8'h90, 3'd1, 1'b0, 1'b1},
        {6'o73, 4'd4,  4'd11, 4'd10, 8'hA0, 3'd1, 1'b0, 1'b1},
        {6'o74, 4'd1,  4'd12, 4'd1,  8'h02, 3'd1, 1'b0, 1'b1},
        {6'o74, 4'd2,  4'd12, 4'd1,  8'h02, 3'd1, 1'b0, 1'b1},
        {6'o74, 4'd4,  4'd12, 4'd1,  8'h02, 3'd2, 1'b0, 1'b1},
        {6'o74, 4'd8,  4'd12, 4'd1,  8'h02, 3'd4, 1'b0, 1'b1},
        {6'o74, 4'd12, 4'd12, 4'd1,  8'h02, 3'd6, 1'b0, 1'b1},
        {6'o75, 4'd4,  4'd13, 4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o76, 4'd4,  4'd14, 4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o77, 4'd4,  4'd15, 4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o25, 4'd3,  4'd13, 4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o03, 4'd0,  4'd3,  4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o74, 4'd13, 4'd12, 4'd15, 8'h00, 3'd0, 1'b1, 1'b0},
        {6'o03, 4'd1,  4'd3,  4'd0,  8'h01, 3'd0, 1'b0, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [5:0] f, input logic [3:0] cls,
                                     input logic il, input logic [3:0] sz);
        if (il) return (f[5:3] == 3'd7 && f[2:0] > 3'd4) ? "R6" : "R7";
        if (cls == 4'd0) return "R1";
        if (cls == 4'd1) return "R5";
        if (cls >= 4'd7) return "R4";
        return (sz == 4'd0) ? "R3" : "R3";
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R11", "results", {9'd0, reg_num, mode_class, flags, ext_words,
              illegal, not_alterable}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // table walk, back to back
        for (int i = 0; i <= NV; i++) begin
            if (i > 0) begin
                logic [30:0] v;
                string t;
                v = VEC[i-1];
                t = tag_of(v[30:25], v[16:13], v[1], v[24:21]);
                check("R10", "out_valid", {31'd0, out_valid}, 32'd1);
                check(v[30:29] == 2'b00 ? "R1" : "R2", "reg_num",
                      {28'd0, reg_num}, {28'd0, v[20:17]});
                check(v[1] ? "R8" : t, "class", {28'd0, mode_class}, {28'd0, v[16:13]});
                check(v[1] ? "R8" : t, "flags", {24'd0, flags}, {24'd0, v[12:5]});
                check(v[1] ? "R8" : t, "ext_words", {29'd0, ext_words}, {29'd0, v[4:2]});
                check(t, "illegal", {31'd0, illegal}, {31'd0, v[1]});
                check("R9", "not_alterable", {31'd0, not_alterable}, {31'd0, v[0]});
            end
            if (i < NV) begin
                in_valid   = 1'b1;
                modereg    = VEC[i][30:25];
                size_bytes = VEC[i][24:21];
            end else begin
                in_valid = 1'b0;
            end
            @(negedge clk);
        end

        // R10: idle input changes have no effect, valid drops
        modereg = 6'o74; size_bytes = 4'd12;
        @(negedge clk);
        @(negedge clk);
        check("R10", "idle out_valid", {31'd0, out_valid}, 32'd0);
        check("R10", "held reg_num", {28'd0, reg_num}, 32'd3);
        check("R10", "held class", {28'd0, mode_class}, 32'd0);
        check("R10", "held flags", {24'd0, flags}, 32'h01);

        // single strobe then R11 reset mid-stream
        in_valid = 1'b1; modereg = 6'o72; size_bytes = 4'd4;
        @(negedge clk);
        in_valid = 1'b0;
        check("R4", "pc disp class", {28'd0, mode_class}, 32'd9);
        rst = 1'b1;
        @(negedge clk);
        check("R11", "reset out_valid", {31'd0, out_valid}, 32'd0);
        check("R11", "reset results", {9'd0, reg_num, mode_class, flags, ext_words,
              illegal, not_alterable}, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule